// File: doc/BRIEF.md
# Retention Scrub Controller for a Low-Retention Line Array

This block keeps a cache data array made of short-retention memory cells alive. On a programmable period it picks the next line and asks the array arbiter to read it. When the read data comes back, a single-error-correcting, double-error-detecting check classifies it. A clean line is left alone, because reading does not disturb the stored value. A line with one flipped bit is written back in corrected form. A line that cannot be corrected is not written; instead a sticky flag is set and its location is kept. The period is chosen by software as the retention time divided by the total line count. Lines are visited bank-interleaved, so in a multi-bank array each bank sees a new refresh once every `NUM_BANKS` periods.

The request port toward the arbiter is valid/ready. `req_valid` rises with a read or a write. Once raised, it stays high with the same command, bank, line and write data until a cycle where `req_ready` is high. That cycle completes the transfer. The response port carries data only: `rsp_ready` is high exactly while a read is outstanding, and a beat transfers on a cycle where `rsp_valid` and `rsp_ready` are both high. Any `rsp_valid` outside that window is dropped. While a request waits without a grant, an age counter runs. When it reaches a programmable slack, `req_urgent` asks the arbiter to favour the refresh over normal traffic. A force mode writes back every correctable or clean line, so the worst-case write load can be measured. Three counters track reads issued, writebacks performed and uncorrectable lines.

Top module: `line_scrub_ctrl`

## Requirements
- R1: After reset `req_valid`, `rsp_ready` and `err_flag` are low and all three counters are zero. The first refresh read targets bank 0, line 0.
- R2: An interval timer is reloaded whenever a refresh starts. With prompt grants, consecutive refresh reads first appear exactly `cfg_interval` cycles apart, and a value of 0 acts as 1. If the period expires while a refresh is in progress, the next one starts on the first idle cycle.
- R3: Refreshes step through all locations with the bank index changing fastest: bank 0..NUM_BANKS-1 of line 0, then of line 1, and so on. After the last bank of the last line, the sequence wraps to bank 0, line 0.
- R4: While `req_valid` is high and `req_ready` is low, the request and all its fields hold unchanged on the next cycle.
- R5: The codeword is 13 bits for 8 data bits. Bit 0 is even parity over the whole word. Bits 1, 2, 4 and 8 are check bits: the check bit at 2^k gives even parity over all positions 1..12 whose index has bit k set. The data fills positions 3, 5, 6, 7, 9, 10, 11 and 12 in ascending order, with the data LSB at position 3. A clean read with force mode off causes no writeback.
- R6: A word with exactly one flipped bit, at any position 0..12, is written back once. The write goes to the same bank and line, with the original clean codeword as data, before the next refresh read.
- R7: A word with a nonzero syndrome and even overall parity, or with odd overall parity and a syndrome above 12, is uncorrectable. It is never written back. `err_flag` rises and stays high until reset, and `err_bank`/`err_line` show the most recent such location.
- R8: With `cfg_force_wb` high, every clean or correctable line is written back with its corrected data. Uncorrectable lines are still not written.
- R9: `req_urgent` is low while a pending request has waited fewer than `cfg_slack` cycles without a grant. From the `cfg_slack`-th ungranted cycle on it is high. It is high at once when `cfg_slack` is 0.
- R10: `cnt_refresh` counts accepted refresh reads, `cnt_writeback` counts accepted writebacks, and `cnt_uncorr` counts uncorrectable responses. All three wrap at their width.
- R11: A response beat offered while no read is outstanding sees `rsp_ready` low. It changes no counter and the error flag, and causes no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_interval | input | IVL_W (16) | Cycles between refresh starts |
| cfg_slack | input | IVL_W (16) | Ungranted wait cycles before urgency |
| cfg_force_wb | input | 1 | Write back every non-fatal line |
| req_valid | output | 1 | Request to the array arbiter |
| req_ready | input | 1 | Arbiter grant for the current request |
| req_write | output | 1 | 1 = writeback, 0 = refresh read |
| req_bank | output | BANK_W (2) | Bank index of the request |
| req_line | output | LINE_W (3) | Line index within the bank |
| req_wdata | output | 13 | Corrected codeword for a writeback |
| req_urgent | output | 1 | Request has waited past the slack |
| rsp_valid | input | 1 | Read data beat from the array |
| rsp_ready | output | 1 | A read is outstanding |
| rsp_data | input | 13 | Codeword returned by the array |
| err_flag | output | 1 | Sticky uncorrectable indication |
| err_bank | output | BANK_W (2) | Bank of the last uncorrectable line |
| err_line | output | LINE_W (3) | Line of the last uncorrectable line |
| cnt_refresh | output | CNT_W (16) | Accepted refresh reads |
| cnt_writeback | output | CNT_W (16) | Accepted writebacks |
| cnt_uncorr | output | CNT_W (16) | Uncorrectable responses |

## Verification
The bench flips a single bit at every position, including the overall parity bit 0. A decoder that mishandles bit 0 would write back a wrong word or flag the line as fatal. A three-bit pattern with a syndrome of 15 must be treated as uncorrectable; a decoder that trusts any syndrome would flip a bit outside the word and write garbage back. The bench holds the grant low under random back-pressure, so a design that moves on before the grant would skip or repeat a line. It also checks that the scan wraps after 32 locations, that start times fall exactly one period apart, and that urgency rises exactly at the slack (with a separate check at zero slack). A stray response while idle must leave every counter untouched.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  // number of Hamming check bits for dw data bits
  function automatic int chk_bits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  // full codeword width: data + check bits + overall parity
  function automatic int cw_width(input int dw);
    return dw + chk_bits(dw) + 1;
  endfunction

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WAIT,
    ST_WR
  } scrub_state_t;

endpackage

// File: rtl/scrub_secded.sv
module scrub_secded #(
  parameter int DATA_W = 8
) (
  input  logic [scrub_pkg::cw_width(DATA_W)-1:0] cw_in,
  output logic [scrub_pkg::cw_width(DATA_W)-1:0] cw_fix,
  output logic                                   err_corr,
  output logic                                   err_uncorr
);
  localparam int SYN_W = scrub_pkg::chk_bits(DATA_W);
  localparam int N     = DATA_W + SYN_W;
  localparam int CW    = N + 1;

  logic [SYN_W-1:0] syn;
  logic             ovr;
  logic             in_range;

  // syndrome: xor of the indices of all set bits in positions 1..N
  always_comb begin
    syn = '0;
    for (int i = 1; i <= N; i++) begin
      if (cw_in[i]) syn = syn ^ SYN_W'(i);
    end
    ovr = ^cw_in;
  end

  assign in_range   = (int'(syn) <= N);
  assign err_corr   = ovr && in_range;
  assign err_uncorr = (!ovr && (syn != '0)) || (ovr && !in_range);
  assign cw_fix     = err_corr ? (cw_in ^ (CW'(1) << syn)) : cw_in;

endmodule

// File: rtl/scrub_timer.sv
module scrub_timer #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IVL_W-1:0] cfg_interval,
  input  logic [IVL_W-1:0] cfg_slack,
  input  logic             start,
  input  logic             req_valid,
  input  logic             req_ready,
  output logic             due,
  output logic             urgent
);
  logic [IVL_W-1:0] ivl_q;
  logic [IVL_W-1:0] age_q;
  logic [IVL_W-1:0] reload;

  assign reload = (cfg_interval == '0) ? '0 : cfg_interval - 1'b1;
  assign due    = (ivl_q == '0);

  // period counter: reloaded at refresh start, holds at zero when expired
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ivl_q <= '0;
    else if (start)  ivl_q <= reload;
    else if (!due)   ivl_q <= ivl_q - 1'b1;
  end

  // age of the pending request, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       age_q <= '0;
    else if (!req_valid || req_ready) age_q <= '0;
    else if (age_q != '1)             age_q <= age_q + 1'b1;
  end

  assign urgent = req_valid && (age_q >= cfg_slack);

  AST_RELOAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cfg_interval > 1) |=> !due); // R2
  AST_DUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (due && !start) |=> due); // R2
  AST_URGENT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent && !req_ready) |=> (urgent || cfg_slack != $past(cfg_slack))); // R9

endmodule

// File: rtl/scrub_ptr.sv
module scrub_ptr #(
  parameter int NUM_BANKS = 4,
  parameter int NUM_LINES = 8,
  parameter int BANK_W    = 2,
  parameter int LINE_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  output logic [BANK_W-1:0] bank,
  output logic [LINE_W-1:0] line
);
  localparam logic [BANK_W-1:0] BANK_LAST = BANK_W'(NUM_BANKS - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(NUM_LINES - 1);

  logic              bank_last;
  logic [LINE_W-1:0] line_q;

  generate
    if (NUM_BANKS > 1) begin : g_multi
      logic [BANK_W-1:0] bank_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       bank_q <= '0;
        else if (advance) bank_q <= (bank_q == BANK_LAST) ? '0 : bank_q + 1'b1;
      end
      assign bank_last = (bank_q == BANK_LAST);
      assign bank      = bank_q;
    end else begin : g_single
      assign bank_last = 1'b1;
      assign bank      = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    line_q <= '0;
    else if (advance && bank_last) line_q <= (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
  end

  assign line = line_q;

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && bank_last && line_q == LINE_LAST) |=> (line_q == '0 && bank == '0)); // R3

endmodule

// File: rtl/line_scrub_ctrl.sv
module line_scrub_ctrl #(
  parameter int NUM_BANKS = 4,
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 8,
  parameter int IVL_W     = 16,
  parameter int CNT_W     = 16
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic [IVL_W-1:0]                              cfg_interval,
  input  logic [IVL_W-1:0]                              cfg_slack,
  input  logic                                          cfg_force_wb,
  output logic                                          req_valid,
  input  logic                                          req_ready,
  output logic                                          req_write,
  output logic [scrub_pkg::idx_width(NUM_BANKS)-1:0]    req_bank,
  output logic [scrub_pkg::idx_width(NUM_LINES)-1:0]    req_line,
  output logic [scrub_pkg::cw_width(DATA_W)-1:0]        req_wdata,
  output logic                                          req_urgent,
  input  logic                                          rsp_valid,
  output logic                                          rsp_ready,
  input  logic [scrub_pkg::cw_width(DATA_W)-1:0]        rsp_data,
  output logic                                          err_flag,
  output logic [scrub_pkg::idx_width(NUM_BANKS)-1:0]    err_bank,
  output logic [scrub_pkg::idx_width(NUM_LINES)-1:0]    err_line,
  output logic [CNT_W-1:0]                              cnt_refresh,
  output logic [CNT_W-1:0]                              cnt_writeback,
  output logic [CNT_W-1:0]                              cnt_uncorr
);
  import scrub_pkg::*;

  localparam int BANK_W = idx_width(NUM_BANKS);
  localparam int LINE_W = idx_width(NUM_LINES);
  localparam int CW     = cw_width(DATA_W);

  scrub_state_t      state_q;
  logic              due;
  logic              start;
  logic              advance;
  logic              rsp_take;
  logic              need_wb;
  logic [CW-1:0]     dec_fix;
  logic              dec_corr;
  logic              dec_uncorr;
  logic [CW-1:0]     wdata_q;
  logic [BANK_W-1:0] ptr_bank;
  logic [LINE_W-1:0] ptr_line;

  assign start    = (state_q == ST_IDLE) && due;
  assign rsp_take = (state_q == ST_WAIT) && rsp_valid;
  assign need_wb  = !dec_uncorr && (dec_corr || cfg_force_wb);
  assign advance  = (rsp_take && !need_wb) || (state_q == ST_WR && req_ready);

  scrub_timer #(.IVL_W(IVL_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_interval (cfg_interval),
    .cfg_slack    (cfg_slack),
    .start        (start),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .due          (due),
    .urgent       (req_urgent)
  );

  scrub_ptr #(
    .NUM_BANKS (NUM_BANKS),
    .NUM_LINES (NUM_LINES),
    .BANK_W    (BANK_W),
    .LINE_W    (LINE_W)
  ) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .bank    (ptr_bank),
    .line    (ptr_line)
  );

  scrub_secded #(.DATA_W(DATA_W)) u_dec (
    .cw_in      (rsp_data),
    .cw_fix     (dec_fix),
    .err_corr   (dec_corr),
    .err_uncorr (dec_uncorr)
  );

  // refresh sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (due) state_q <= ST_RD;
        ST_RD:   if (req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          if (need_wb) begin
            state_q <= ST_WR;
            wdata_q <= dec_fix;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_WR:   if (req_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // uncorrectable record and event counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag      <= 1'b0;
      err_bank      <= '0;
      err_line      <= '0;
      cnt_refresh   <= '0;
      cnt_writeback <= '0;
      cnt_uncorr    <= '0;
    end else begin
      if (rsp_take && dec_uncorr) begin
        err_flag   <= 1'b1;
        err_bank   <= ptr_bank;
        err_line   <= ptr_line;
        cnt_uncorr <= cnt_uncorr + 1'b1;
      end
      if (state_q == ST_RD && req_ready) cnt_refresh   <= cnt_refresh + 1'b1;
      if (state_q == ST_WR && req_ready) cnt_writeback <= cnt_writeback + 1'b1;
    end
  end

  assign req_valid = (state_q == ST_RD) || (state_q == ST_WR);
  assign req_write = (state_q == ST_WR);
  assign req_bank  = ptr_bank;
  assign req_line  = ptr_line;
  assign req_wdata = wdata_q;
  assign rsp_ready = (state_q == ST_WAIT);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_write) && $stable(req_bank)
                                   && $stable(req_line) && $stable(req_wdata))); // R4
  AST_CLEAN_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && !dec_corr && !dec_uncorr && !cfg_force_wb) |=> !req_valid); // R5
  AST_CORR_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && dec_corr) |=> (req_valid && req_write)); // R6
  AST_UNCORR_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && dec_uncorr) |=> (!req_valid && err_flag)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R7
  AST_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> $stable(cnt_uncorr)); // R11

endmodule

// File: tb/line_scrub_ctrl_bench.sv
module line_scrub_ctrl_bench;
  localparam int CLK_P  = 10;
  localparam int NB     = 4;
  localparam int NL     = 8;
  localparam int WDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_interval = 16'd20;
  logic [15:0] cfg_slack = 16'd3;
  logic        cfg_force_wb = 1'b0;
  logic        req_valid, req_write, req_urgent, rsp_ready, err_flag;
  logic        req_ready = 1'b0;
  logic [1:0]  req_bank, err_bank;
  logic [2:0]  req_line, err_line;
  logic [12:0] req_wdata;
  logic        resp_v = 1'b0, stray_v = 1'b0;
  logic [12:0] resp_d = '0, stray_d = '0;
  logic        rsp_valid;
  logic [12:0] rsp_data;
  logic [15:0] cnt_refresh, cnt_writeback, cnt_uncorr;

  assign rsp_valid = resp_v | stray_v;
  assign rsp_data  = stray_v ? stray_d : resp_d;

  line_scrub_ctrl u_line_scrub_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval), .cfg_slack(cfg_slack),
    .cfg_force_wb(cfg_force_wb), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_line(req_line),
    .req_wdata(req_wdata), .req_urgent(req_urgent), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .err_flag(err_flag),
    .err_bank(err_bank), .err_line(err_line), .cnt_refresh(cnt_refresh),
    .cnt_writeback(cnt_writeback), .cnt_uncorr(cnt_uncorr)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG);
      report();
    end
  end

  // reference encoder for the R5 layout
  function automatic logic [12:0] enc(input logic [7:0] d);
    logic [12:0] c;
    int k;
    c = '0; k = 0;
    for (int pos = 1; pos <= 12; pos++)
      if ((pos & (pos - 1)) != 0) begin c[pos] = d[k]; k++; end
    for (int b = 0; b < 4; b++) begin
      logic x;
      x = 1'b0;
      for (int pos = 1; pos <= 12; pos++)
        if (((pos >> b) & 1) == 1 && pos != (1 << b)) x = x ^ c[pos];
      c[1 << b] = x;
    end
    c[0] = ^c[12:1];
    return c;
  endfunction

  // bench model state
  logic [12:0] mem [NB*NL];
  int  seq = 0, n_reads = 0, n_wb = 0, exp_uncorr = 0;
  int  exp_eb = 0, exp_el = 0;
  bit  exp_flag = 1'b0;
  int  ready_mode = 0, lat_max = 1, inj = 0;
  bit  outstanding = 1'b0, wb_pending = 1'b0;
  int  delay = 0, cur_idx = 0, cur_b = 0, cur_l = 0, post_kind = 0;
  logic [12:0] exp_wdata;
  bit  prev_stall = 1'b0, prev_w;
  logic [1:0] prev_b; logic [2:0] prev_l; logic [12:0] prev_d;
  bit  gap_on = 1'b0;
  int  last_start = -1, gap_ivl = 20;

  always @(negedge clk) if (rst_n && !done) begin
    bit hs;
    // response beat accepted at the previous edge
    if (resp_v) begin
      resp_v = 1'b0;
      if (post_kind == 1) chk(!req_valid, "R5/R7 no writeback after clean or fatal", req_valid, 0);
      if (post_kind == 2) chk(req_valid && req_write, "R6/R8 writeback follows", {req_valid, req_write}, 3);
      post_kind = 0;
    end
    // back-pressure rule
    if (prev_stall)
      chk(req_valid && req_write == prev_w && req_bank == prev_b && req_line == prev_l
          && req_wdata == prev_d, "R4 request held under back-pressure",
          {req_valid, req_write, req_bank, req_line}, {1'b1, prev_w, prev_b, prev_l});
    // read start spacing
    if (req_valid && !req_write && !prev_stall) begin
      if (gap_on && last_start >= 0) chk(cyc - last_start == gap_ivl, "R2 start spacing", cyc - last_start, gap_ivl);
      last_start = cyc;
    end
    // read response
    if (outstanding) begin
      delay--;
      if (delay == 0) begin
        int r, p1, p2;
        logic [12:0] mask;
        chk(rsp_ready, "R11 rsp_ready while read outstanding", rsp_ready, 1);
        mask = '0; r = 0;
        if (inj == 1) r = $urandom % 4;
        if (inj == 2) r = 4;
        if (r == 1 || r == 2) begin p1 = $urandom % 13; mask[p1] = 1'b1; end
        if (r == 3) begin
          p1 = $urandom % 13; p2 = (p1 + 1 + $urandom % 12) % 13;
          mask[p1] = 1'b1; mask[p2] = 1'b1;
        end
        if (r == 4) mask = 13'b1_0000_0000_0110;  // syndrome 15, odd parity
        resp_d = mem[cur_idx] ^ mask;
        resp_v = 1'b1;
        outstanding = 1'b0;
        if (r >= 3) begin
          exp_uncorr++; exp_flag = 1'b1; exp_eb = cur_b; exp_el = cur_l;
          post_kind = 1;
        end else if (r != 0 || cfg_force_wb) begin
          wb_pending = 1'b1; exp_wdata = mem[cur_idx]; post_kind = 2;
        end else begin
          post_kind = 1;
        end
      end
    end
    // grant for the coming edge
    if (ready_mode == 0) req_ready = 1'b1;
    else if (ready_mode == 1) req_ready = ($urandom % 3) != 0;
    else req_ready = 1'b0;
    hs = req_valid && req_ready;
    if (hs && !req_write) begin
      int eb, el;
      eb = seq % NB; el = (seq / NB) % NL;
      if (seq == 0) chk(req_bank == 0 && req_line == 0, "R1 first refresh at bank0 line0", {req_bank, req_line}, 0);
      chk(req_bank == eb && req_line == el, "R3 scan order", {req_bank, req_line}, {eb[1:0], el[2:0]});
      chk(!wb_pending, "R6 writeback precedes next read", wb_pending, 0);
      cur_b = req_bank; cur_l = req_line; cur_idx = req_line * NB + req_bank;
      seq++; n_reads++;
      outstanding = 1'b1;
      delay = 1 + ($urandom % lat_max);
    end
    if (hs && req_write) begin
      n_wb++;
      if (!wb_pending) chk(1'b0, "R5 unexpected writeback", 1, 0);
      else begin
        chk(req_bank == cur_b && req_line == cur_l, "R6 writeback address", {req_bank, req_line}, {cur_b[1:0], cur_l[2:0]});
        chk(req_wdata == exp_wdata, "R6/R8 writeback data", req_wdata, exp_wdata);
        mem[cur_idx] = req_wdata;
      end
      wb_pending = 1'b0;
    end
    prev_stall = req_valid && !hs;
    prev_w = req_write; prev_b = req_bank; prev_l = req_line; prev_d = req_wdata;
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic bit quiet();
    return !outstanding && !resp_v && !wb_pending && !req_valid && !rsp_ready;
  endfunction

  task automatic wait_quiet();
    do tick(); while (!quiet());
  endtask

  task automatic wait_reads(input int n);
    while (n_reads < n) tick();
  endtask

  initial begin
    int n;
    logic [15:0] c_u, c_w;
    void'($urandom(32'd4242));
    for (int i = 0; i < NB * NL; i++) mem[i] = enc(8'($urandom));
    repeat (3) tick();
    chk(!req_valid && !rsp_ready && !err_flag, "R1 reset outputs", {req_valid, rsp_ready, err_flag}, 0);
    chk(cnt_refresh == 0 && cnt_writeback == 0 && cnt_uncorr == 0, "R1 reset counters",
        {cnt_refresh, cnt_writeback, cnt_uncorr}, 0);
    rst_n = 1'b1;

    // prompt grants, clean data: spacing, order, wrap, no writeback
    gap_on = 1'b1;
    wait_reads(40);
    gap_on = 1'b0;
    wait_quiet();
    chk(cnt_writeback == 0, "R5 no writeback on clean lines", cnt_writeback, 0);

    // random back-pressure, latency and single/double errors
    cfg_interval = 16'd6; ready_mode = 1; lat_max = 3; inj = 1;
    wait_reads(190);
    wait_quiet();

    // directed fatal pattern with out-of-range syndrome
    inj = 2;
    wait_reads(n_reads + 3);
    inj = 0;
    wait_reads(n_reads + 4);
    wait_quiet();
    chk(err_flag == exp_flag, "R7 sticky flag after later clean lines", err_flag, exp_flag);
    chk(err_bank == exp_eb && err_line == exp_el, "R7 recorded location", {err_bank, err_line}, {exp_eb[1:0], exp_el[2:0]});

    // force mode, clean then mixed
    cfg_force_wb = 1'b1;
    wait_reads(n_reads + 20);
    inj = 1;
    wait_reads(n_reads + 30);
    wait_quiet();
    cfg_force_wb = 1'b0; inj = 0;

    // urgency after the slack
    cfg_slack = 16'd5; ready_mode = 2;
    do tick(); while (!req_valid);
    n = 0;
    while (!req_urgent && n < 50) begin n++; tick(); end
    chk(n == 5 && req_urgent, "R9 urgency at slack 5", n, 5);
    ready_mode = 0;
    wait_quiet();
    cfg_slack = 16'd0; ready_mode = 2;
    do tick(); while (!req_valid);
    chk(req_urgent, "R9 urgency at slack 0", req_urgent, 1);
    ready_mode = 0;
    wait_quiet();

    // stray response while idle
    cfg_interval = 16'd200;
    wait_reads(n_reads + 1);
    wait_quiet();
    c_u = cnt_uncorr; c_w = cnt_writeback;
    stray_d = mem[0] ^ 13'b0_0000_0000_0110;
    stray_v = 1'b1;
    chk(!rsp_ready, "R11 rsp_ready low when idle", rsp_ready, 0);
    tick();
    stray_v = 1'b0;
    repeat (4) tick();
    chk(cnt_uncorr == c_u && cnt_writeback == c_w, "R11 stray beat ignored",
        {cnt_uncorr, cnt_writeback}, {c_u, c_w});
    wait_quiet();

    chk(cnt_refresh == 16'(n_reads), "R10 refresh count", cnt_refresh, n_reads);
    chk(cnt_writeback == 16'(n_wb), "R10 writeback count", cnt_writeback, n_wb);
    chk(cnt_uncorr == 16'(exp_uncorr), "R10 uncorrectable count", cnt_uncorr, exp_uncorr);
    chk(err_flag == exp_flag, "R7 flag at end", err_flag, exp_flag);
    report();
  end

endmodule